// File: doc/BRIEF.md
# Serial Management Bus Master

This block is a register-programmed master for the two-wire station management bus that links a MAC to its external PHYs. It carries out one clause-22 read or write at a time. Software programs an enable bit and a clock divider in a control word. It then writes a single packed access word that holds the operation, the PHY address, the register address and, for a write, the data. The go bit in that word starts the transaction. The block clears go when the frame is finished. For a read it returns the PHY's acknowledge and the 16 sampled data bits in the same word.

The management clock comes from the system clock through a programmable divider. The data line is handled through separate output, output-enable and input signals, so a pad or tristate buffer can be placed outside the block. Output bits change when the management clock falls and input bits are sampled when it rises. A third word is a plain writable link mirror with no hardware behaviour.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word (select 0) reads 0x8000_0000, with idle set, enable clear and divider 0. The access word (select 1) reads 0. `mdc` and `mdio_oe` are low.
- R2: While enable (control bit 30) is set, `mdc` has a period of 2*(div+1) system clocks, where div is control bits DIV_W-1:0. While enable is clear, `mdc` is held low.
- R3: A go request (access bit 31) starts a frame only while enable is set. Control bit 31 reads 0 while a frame is in progress and 1 otherwise.
- R4: A write (access bit 30 = 1) sends 64 bits, MSB first, with `mdio_oe` high throughout: 32 ones, 01, 01, PHY address (access bits 20:16), register address (access bits 25:21), 10, then the 16 data bits (access bits 15:0).
- R5: A read (access bit 30 = 0) sends 32 ones, 01, 10, the PHY address and the register address with `mdio_oe` high. It then holds `mdio_oe` low for the remaining 18 bit times.
- R6: On a read, access bit 29 is set only if `mdio_i` was low at the second turnaround bit. Bits 15:0 then hold the 16 bits sampled on rising `mdc`, MSB first. After a write, or a read with no acknowledge, bit 29 reads 0.
- R7: The block clears the go bit once the 64th rising `mdc` edge of the frame has passed.
- R8: A write to the access word while go is set has no effect on any of its fields or on the frame in progress.
- R9: The link word (select 2) stores all 32 written bits and reads them back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select: 0 control, 1 access, 2 link |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The assertions assume that software leaves the divider and the enable bit alone while a frame is running, and that `mdio_i` is driven only while the block has released the line. The bench keeps within these limits. It changes the control word only between frames, and its PHY model changes `mdio_i` only on falling `mdc` edges, reporting ones outside the turnaround and data bits. The sweep covers the divider settings 0, 1 and 3. At each setting it runs writes, acknowledged reads and unacknowledged reads with several address and data patterns, and it computes the expected 64-bit frame and output-enable pattern arithmetically.

// File: rtl/mdio_pkg.sv
// Shared constants of the management bus master: register word selects and
// the bit positions inside the control and access words.
package mdio_pkg;
    localparam int unsigned ADDR_W  = 5;
    localparam int unsigned DATA_W  = 16;

    localparam logic [1:0]  SEL_CTL  = 2'd0;
    localparam logic [1:0]  SEL_ACC  = 2'd1;
    localparam logic [1:0]  SEL_LINK = 2'd2;

    localparam int unsigned GO_POS   = 31;
    localparam int unsigned WR_POS   = 30;
    localparam int unsigned ACK_POS  = 29;
    localparam int unsigned REG_LSB  = 21;
    localparam int unsigned PHY_LSB  = 16;

    localparam int unsigned IDLE_POS = 31;
    localparam int unsigned EN_POS   = 30;
endpackage

// File: rtl/mdio_clkgen.sv
// Management clock generator. Divides clk by 2*(div+1) while en is high and
// holds mdc low otherwise. rise_stb/fall_stb are high in the cycle whose
// closing edge makes mdc rise/fall. Assumes div is stable while running.
module mdio_clkgen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    // Terminal count of the half-period counter.
    assign wrap     = en && (cnt == div);
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame serialiser. On start it loads a full clause-22 frame, drives one bit
// per falling-edge strobe and samples the line on each following rising-edge
// strobe. On a read it releases the line from the turnaround on. done pulses
// for one cycle after the last rising edge. Assumes the strobes never
// coincide.
module mdio_frame_engine #(
    parameter int unsigned PRE_LEN = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         wr,
    input  logic [mdio_pkg::ADDR_W-1:0]  phy,
    input  logic [mdio_pkg::ADDR_W-1:0]  regad,
    input  logic [mdio_pkg::DATA_W-1:0]  wdata,
    input  logic                         rise_stb,
    input  logic                         fall_stb,
    input  logic                         mdio_i,
    output logic                         mdio_o,
    output logic                         mdio_oe,
    output logic                         busy,
    output logic                         done,
    output logic                         ack,
    output logic [mdio_pkg::DATA_W-1:0]  rdata
);
    localparam int unsigned FRAME_LEN = PRE_LEN + 32;
    localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] TA_LO = IDX_W'(PRE_LEN + 14);
    localparam logic [IDX_W-1:0] TA_HI = IDX_W'(PRE_LEN + 15);
    localparam logic [IDX_W-1:0] DAT_LO = IDX_W'(PRE_LEN + 16);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(FRAME_LEN - 1);

    logic [FRAME_LEN-1:0] frame;
    logic [FRAME_LEN-1:0] sh;
    logic [IDX_W-1:0]     idx;
    logic                 driven;
    logic                 wr_q;

    // Frame image: preamble, start, opcode, addresses, turnaround, data.
    assign frame = {{PRE_LEN{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, regad,
                    (wr ? 2'b10 : 2'b11), (wr ? wdata : 16'hFFFF)};

    // Bit sequencer: load, shift out on falls, sample on rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            driven  <= 1'b0;
            idx     <= '0;
            sh      <= '0;
            wr_q    <= 1'b0;
            ack     <= 1'b0;
            rdata   <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                mdio_o  <= 1'b1;
                mdio_oe <= 1'b0;
                driven  <= 1'b0;
                if (start) begin
                    busy  <= 1'b1;
                    idx   <= '0;
                    sh    <= frame;
                    wr_q  <= wr;
                    ack   <= 1'b0;
                    rdata <= '0;
                end
            end else if (fall_stb) begin
                mdio_o  <= sh[FRAME_LEN-1];
                sh      <= sh << 1;
                mdio_oe <= wr_q || (idx < TA_LO);
                driven  <= 1'b1;
            end else if (rise_stb && driven) begin
                driven <= 1'b0;
                if (idx == TA_HI)
                    ack <= !mdio_i;
                if (idx >= DAT_LO)
                    rdata <= {rdata[mdio_pkg::DATA_W-2:0], mdio_i};
                if (idx == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Register-driven management bus master. Holds the control, access and link
// words and launches one frame per accepted go request. Assumes software
// does not change the control word during a frame.
module mdio_master #(
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    import mdio_pkg::*;

    logic                ctl_en;
    logic [DIV_W-1:0]    ctl_div;
    logic                acc_go;
    logic                acc_wr;
    logic                acc_ack;
    logic [ADDR_W-1:0]   acc_reg;
    logic [ADDR_W-1:0]   acc_phy;
    logic [DATA_W-1:0]   acc_data;
    logic [31:0]         link_word;

    logic                rise_stb;
    logic                fall_stb;
    logic                busy;
    logic                eng_done;
    logic                eng_ack;
    logic [DATA_W-1:0]   eng_rdata;
    logic                start;
    logic                idle_w;

    assign idle_w = !busy;
    assign start  = acc_go && ctl_en && !busy && !eng_done;

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctl_en),
        .div      (ctl_div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wr       (acc_wr),
        .phy      (acc_phy),
        .regad    (acc_reg),
        .wdata    (acc_data),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .busy     (busy),
        .done     (eng_done),
        .ack      (eng_ack),
        .rdata    (eng_rdata)
    );

    // Control and link words: plain software-written storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en    <= 1'b0;
            ctl_div   <= '0;
            link_word <= '0;
        end else if (reg_wr) begin
            if (reg_addr == SEL_CTL) begin
                ctl_en  <= reg_wdata[EN_POS];
                ctl_div <= reg_wdata[DIV_W-1:0];
            end
            if (reg_addr == SEL_LINK)
                link_word <= reg_wdata;
        end
    end

    // Access word: accepted only while go is clear, updated at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_go   <= 1'b0;
            acc_wr   <= 1'b0;
            acc_ack  <= 1'b0;
            acc_reg  <= '0;
            acc_phy  <= '0;
            acc_data <= '0;
        end else if (eng_done) begin
            acc_go  <= 1'b0;
            acc_ack <= eng_ack && !acc_wr;
            if (!acc_wr)
                acc_data <= eng_rdata;
        end else if (reg_wr && (reg_addr == SEL_ACC) && !acc_go) begin
            acc_go   <= reg_wdata[GO_POS];
            acc_wr   <= reg_wdata[WR_POS];
            acc_ack  <= 1'b0;
            acc_reg  <= reg_wdata[REG_LSB +: ADDR_W];
            acc_phy  <= reg_wdata[PHY_LSB +: ADDR_W];
            acc_data <= reg_wdata[DATA_W-1:0];
        end
    end

    // Read multiplexer over the three words.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_CTL: begin
                reg_rdata[IDLE_POS]    = idle_w;
                reg_rdata[EN_POS]      = ctl_en;
                reg_rdata[DIV_W-1:0]   = ctl_div;
            end
            SEL_ACC: begin
                reg_rdata[GO_POS]              = acc_go;
                reg_rdata[WR_POS]              = acc_wr;
                reg_rdata[ACK_POS]             = acc_ack;
                reg_rdata[REG_LSB +: ADDR_W]   = acc_reg;
                reg_rdata[PHY_LSB +: ADDR_W]   = acc_phy;
                reg_rdata[DATA_W-1:0]          = acc_data;
            end
            SEL_LINK: reg_rdata = link_word;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_master_chk.sv
// Property checker for mdio_master, attached by bind. Relates the clock
// output, the line enable and the access word to the engine's idle state.
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic ctl_en,
    input logic mdc,
    input logic mdio_oe,
    input logic idle_w,
    input logic acc_go,
    input logic acc_wr,
    input logic acc_ack
);
    // R2
    mdc_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> !mdc);

    // R3
    busy_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_w |-> acc_go);

    // R3
    line_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_w && $past(idle_w)) |-> !mdio_oe);

    // R7
    go_clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_go) |-> idle_w);

    // R6
    ack_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_ack) |-> !acc_wr);

    // R8
    op_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && $past(acc_go)) |-> $stable(acc_wr));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_en  (ctl_en),
    .mdc     (mdc),
    .mdio_oe (mdio_oe),
    .idle_w  (idle_w),
    .acc_go  (acc_go),
    .acc_wr  (acc_wr),
    .acc_ack (acc_ack)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
// Sweep bench for mdio_master with a behavioural PHY on the data line.
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int          vectors = 0;
    int          errors = 0;

    // PHY model state
    logic        armed = 1'b0;
    logic        seen_fall = 1'b0;
    int          rises = 0;
    logic [63:0] cap = '0;
    logic [63:0] oev = '0;
    logic        phy_ack_en = 1'b0;
    logic [15:0] phy_rdata = '0;

    always #2 clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY drives the line on falling mdc during turnaround and data.
    always @(negedge mdc) begin
        if (armed) begin
            seen_fall = 1'b1;
            if (phy_ack_en && rises == 47)
                mdio_i = 1'b0;
            else if (phy_ack_en && rises >= 48 && rises <= 63)
                mdio_i = phy_rdata[63 - rises];
            else
                mdio_i = 1'b1;
        end
    end

    // Frame capture on rising mdc.
    always @(posedge mdc) begin
        if (armed && seen_fall && rises < 64) begin
            cap = {cap[62:0], mdio_o};
            oev = {oev[62:0], mdio_oe};
            rises = rises + 1;
        end
    end

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(output logic [31:0] acc);
        int n = 0;
        reg_read(2'd1, acc);
        while (acc[31] && n < 20000) begin
            reg_read(2'd1, acc);
            n++;
        end
        armed = 1'b0;
    endtask

    task automatic launch(input logic wr, input logic [4:0] phy,
                          input logic [4:0] rg, input logic [15:0] d,
                          input logic ack_en, input logic [15:0] pdat);
        armed = 1'b0; seen_fall = 1'b0; rises = 0; cap = '0; oev = '0;
        phy_ack_en = ack_en; phy_rdata = pdat;
        reg_write(2'd1, {1'b1, wr, 4'b0, rg, phy, d} & 32'hC3FF_FFFF);
        @(posedge clk);
        #1 armed = 1'b1;
    endtask

    task automatic frame_check(input logic wr, input logic [4:0] phy,
                               input logic [4:0] rg, input logic [15:0] d);
        logic [63:0] ef;
        logic [63:0] eo;
        ef = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
              (wr ? 2'b10 : 2'b11), (wr ? d : 16'hFFFF)};
        eo = wr ? 64'hFFFF_FFFF_FFFF_FFFF : {46'h3FFF_FFFF_FFFF, 18'h0};
        check(rises == 64, "R7 rising edge count", 64'(rises), 64'd64);
        if (wr)
            check(cap == ef, "R4 write frame", cap, ef);
        else
            check(cap[63:18] == ef[63:18], "R5 read header",
                  {18'h0, cap[63:18]}, {18'h0, ef[63:18]});
        check(oev == eo, wr ? "R4 oe pattern" : "R5 oe pattern", oev, eo);
    endtask

    task automatic xfer(input logic wr, input logic [4:0] phy,
                        input logic [4:0] rg, input logic [15:0] d,
                        input logic ack_en, input logic [15:0] pdat);
        logic [31:0] v;
        logic [31:0] acc;
        launch(wr, phy, rg, d, ack_en, pdat);
        repeat (3) @(negedge clk);
        reg_read(2'd0, v);
        check(v[31] == 1'b0, "R3 idle low while busy", 64'(v[31]), 64'd0);
        wait_done(acc);
        check(acc[31] == 1'b0, "R7 go cleared", 64'(acc[31]), 64'd0);
        frame_check(wr, phy, rg, d);
        if (wr) begin
            check(acc[29] == 1'b0, "R6 no ack after write", 64'(acc[29]), 64'd0);
            check(acc[15:0] == d, "R4 data kept", 64'(acc[15:0]), 64'(d));
        end else if (ack_en) begin
            check(acc[29] == 1'b1, "R6 ack set", 64'(acc[29]), 64'd1);
            check(acc[15:0] == pdat, "R6 read data", 64'(acc[15:0]), 64'(pdat));
        end else begin
            check(acc[29] == 1'b0, "R6 no ack", 64'(acc[29]), 64'd0);
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] acc;
        int divs [3] = '{0, 1, 3};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd0, v);
        check(v == 32'h8000_0000, "R1 control reset", 64'(v), 64'h8000_0000);
        reg_read(2'd1, v);
        check(v == 32'h0, "R1 access reset", 64'(v), 64'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins reset",
              {62'h0, mdc, mdio_oe}, 64'h0);

        // R9 link mirror
        reg_write(2'd2, 32'hA5A5_0F0F);
        reg_read(2'd2, v);
        check(v == 32'hA5A5_0F0F, "R9 link readback", 64'(v), 64'hA5A5_0F0F);

        // R3 go while disabled stays pending, mdc parked
        begin
            logic saw_mdc = 1'b0;
            launch(1'b1, 5'h05, 5'h0A, 16'hBEEF, 1'b0, 16'h0);
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (mdc) saw_mdc = 1'b1;
            end
            check(!saw_mdc, "R2 mdc parked while disabled", 64'(saw_mdc), 64'd0);
            reg_read(2'd1, v);
            check(v[31] == 1'b1, "R3 go pending while disabled", 64'(v[31]), 64'd1);
            reg_read(2'd0, v);
            check(v[31] == 1'b1, "R3 idle while disabled", 64'(v[31]), 64'd1);
            reg_write(2'd0, 32'h4000_0000);
            wait_done(acc);
            frame_check(1'b1, 5'h05, 5'h0A, 16'hBEEF);
        end

        // Sweep over divider settings
        foreach (divs[k]) begin
            int t0;
            int t1;
            reg_write(2'd0, 32'h4000_0000 | 32'(divs[k]));
            @(posedge mdc); t0 = int'($time);
            @(posedge mdc); t1 = int'($time);
            check((t1 - t0) == 8 * (divs[k] + 1), "R2 mdc period",
                  64'(t1 - t0), 64'(8 * (divs[k] + 1)));
            xfer(1'b1, 5'h00, 5'h1F, 16'h0000, 1'b0, 16'h0);
            xfer(1'b1, 5'h1F, 5'h00, 16'hA55A, 1'b0, 16'h0);
            xfer(1'b1, 5'(3 * k + 1), 5'(7 * k + 2), 16'(16'h1357 * (k + 1)), 1'b0, 16'h0);
            xfer(1'b0, 5'h11, 5'h02, 16'h0, 1'b1, 16'hC3A5);
            xfer(1'b0, 5'(k + 9), 5'(k + 20), 16'h0, 1'b1, 16'(16'h8001 ^ (k * 16'h0F0F)));
            xfer(1'b0, 5'h03, 5'h01, 16'h0, 1'b0, 16'h0);
        end

        // R8 write while go set is ignored
        launch(1'b0, 5'h0C, 5'h13, 16'h0, 1'b1, 16'h6B2D);
        repeat (12) @(negedge clk);
        reg_write(2'd1, 32'hFFFF_1234);
        reg_read(2'd1, v);
        check(v[30] == 1'b0 && v[25:16] == {5'h13, 5'h0C}, "R8 fields unchanged",
              64'(v[30:16]), 64'({1'b0, 4'b0, 5'h13, 5'h0C}));
        wait_done(acc);
        frame_check(1'b0, 5'h0C, 5'h13, 16'h0);
        check(acc[15:0] == 16'h6B2D && acc[29], "R8 frame unaffected",
              64'({acc[29], acc[15:0]}), 64'({1'b1, 16'h6B2D}));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule